// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable behavioural model of a single-ported synchronous static RAM for a cache data store. Address, write data and all control inputs are sampled on the rising clock edge. The only exceptions are the output enable, which acts without a clock, and the burst-order select, which is a level. A burst begins when one of two strobes opens it:

- The processor strobe always opens a read.
- The controller strobe opens a read or a write, chosen by the write controls.

Once a burst is open, an advance input either steps to the next address in the burst or holds the current one. An internal 2-bit sequencer produces the addresses, in linear or interleaved order.

Writes can target any set of byte lanes, or all lanes at once through a global write enable. Reads go through an output register. The read data and its valid flag therefore appear one clock after the cycle in which the array is accessed. The tri-state data bus is modelled by two outputs: a drive flag, and a data word that is forced to zero whenever the flag is low.

Top module: `burst_sram`

## Requirements
- R1: With the global write enable low, a write cycle writes all four 9-bit lanes, whatever the byte enables and the write enable are.
- R2: With global write high and write enable low, only the lanes whose byte enable is low are written (be_ni bit k controls data bits 9k+8..9k); the other lanes keep their contents.
- R3: With global write high and either write enable high or all byte enables high, a cycle opened by the controller strobe is a read and changes no memory.
- R4: A low processor strobe with all three selects active (sel1_ni low, sel2_i high, sel3_ni low) opens a read at addr_i. This happens whatever the write controls and the controller strobe are.
- R5: A low controller strobe with the processor strobe high and all selects active opens a burst at addr_i. A write cycle drives no data on the bus in the following cycle.
- R6: A strobe taken while a select is inactive deselects the chip, and rd_oe_o is low from the second edge onward. With sel1_ni high, a low processor strobe is ignored and the open burst continues.
- R7: With both strobes inactive and adv_ni low, an open burst steps linearly when order_i is 0: the low two address bits go +1 modulo 4 and the upper bits are fixed. This applies to reads and writes.
- R8: With order_i at 1, the burst offset is the start offset XOR a 2-bit step count (01,00,11,10 from 01).
- R9: With both strobes inactive and adv_ni high, the burst stays at its current address.
- R10: Read data is driven after the second rising edge following the sampled request. A read issued in the cycle after a write to the same address returns the new data.
- R11: rd_oe_o is low at once whenever oe_ni is high, and rd_o is zero whenever rd_oe_o is low.
- R12: While rst_ni is low, rd_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | LANES*LANE_W | Write data, sampled with the address |
| sel1_ni | input | 1 | Primary chip select, active low |
| sel2_i | input | 1 | Second chip select, active high |
| sel3_ni | input | 1 | Third chip select, active low |
| strb_cpu_ni | input | 1 | Processor burst-start strobe, active low |
| strb_ctl_ni | input | 1 | Controller burst-start strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| wr_all_ni | input | 1 | Global write, active low |
| wr_en_ni | input | 1 | Lane write enable, active low |
| be_ni | input | LANES | Per-lane byte enables, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rd_o | output | LANES*LANE_W | Read data, zero when not driven |
| rd_oe_o | output | 1 | Bus drive flag (low means high impedance) |

## Verification
The bench uses the default parameters: 64 words of four 9-bit lanes and a 2-bit burst counter. With these values, a burst started near the top of a 4-word block wraps within a few cycles, so both the linear and the interleaved wrap points are exercised. A 36-bit word also lets every lane carry a distinct value, so a write to the wrong lane shows up on a readback. The small depth keeps the shadow model in the bench trivial, while the address still has upper bits that a burst must leave untouched.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {CYC_IDLE, CYC_READ, CYC_WRITE} cyc_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_START, ACT_NEXT, ACT_HOLD} act_e;
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel1_ni,
  input  logic             sel2_i,
  input  logic             sel3_ni,
  input  logic             strb_cpu_ni,
  input  logic             strb_ctl_ni,
  input  logic             adv_ni,
  input  logic             wr_all_ni,
  input  logic             wr_en_ni,
  input  logic [LANES-1:0] be_ni,
  input  logic             live_i,
  output act_e             act_o,
  output cyc_e             cyc_o,
  output logic [LANES-1:0] lanes_o
);
  logic             sel_ok, cpu_take, ctl_take;
  logic [LANES-1:0] mask;
  cyc_e             rw;

  always_comb begin
    if (!wr_all_ni)     mask = '1;
    else if (!wr_en_ni) mask = ~be_ni;
    else                mask = '0;
    rw       = (|mask) ? CYC_WRITE : CYC_READ;
    sel_ok   = !sel1_ni && sel2_i && !sel3_ni;
    // processor strobe counts only with the primary select active
    cpu_take = !strb_cpu_ni && !sel1_ni;
    ctl_take = !cpu_take && !strb_ctl_ni;
    act_o    = ACT_NONE;
    cyc_o    = CYC_IDLE;
    lanes_o  = '0;
    if (cpu_take) begin
      if (sel_ok) begin
        act_o = ACT_START;
        cyc_o = CYC_READ;
      end
    end else if (ctl_take) begin
      if (sel_ok) begin
        act_o   = ACT_START;
        cyc_o   = rw;
        lanes_o = mask;
      end
    end else if (live_i) begin
      act_o   = adv_ni ? ACT_HOLD : ACT_NEXT;
      cyc_o   = rw;
      lanes_o = mask;
    end
  end
endmodule

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq
  import bsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  act_e              act_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] base_q, cnt_q, offs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (act_i == ACT_START) begin
      hi_q   <= addr_i[ADDR_W-1:BURST_W];
      base_q <= addr_i[BURST_W-1:0];
      cnt_q  <= '0;
    end else if (act_i == ACT_NEXT) begin
      cnt_q  <= cnt_q + BURST_W'(1);
    end
  end

  generate
    if (BURST_W > 0) begin : g_order
      always_comb offs = order_i ? (base_q ^ cnt_q) : (base_q + cnt_q);
    end
  endgenerate

  assign addr_o = {hi_q, offs};
endmodule

// File: rtl/bsram_array.sv
module bsram_array
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  cyc_e                    cyc_i,
  input  logic [LANES-1:0]        lanes_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvld_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk_i) begin
      if (cyc_i == CYC_WRITE && lanes_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (cyc_i == CYC_READ)                q           <= mem[addr_i];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvld_o <= 1'b0;
    else         rvld_o <= (cyc_i == CYC_READ);
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sel1_ni,
  input  logic              sel2_i,
  input  logic              sel3_ni,
  input  logic              strb_cpu_ni,
  input  logic              strb_ctl_ni,
  input  logic              adv_ni,
  input  logic              wr_all_ni,
  input  logic              wr_en_ni,
  input  logic [LANES-1:0]  be_ni,
  input  logic              order_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rd_o,
  output logic              rd_oe_o
);
  act_e              act;
  cyc_e              cyc, cyc_q;
  logic [LANES-1:0]  lanes, lanes_q;
  logic [DATA_W-1:0] wdata_q, rdata;
  logic [ADDR_W-1:0] cur_addr;
  logic              live_q, rvld;

  bsram_decode #(.LANES(LANES)) u_dec (
    .sel1_ni(sel1_ni), .sel2_i(sel2_i), .sel3_ni(sel3_ni),
    .strb_cpu_ni(strb_cpu_ni), .strb_ctl_ni(strb_ctl_ni), .adv_ni(adv_ni),
    .wr_all_ni(wr_all_ni), .wr_en_ni(wr_en_ni), .be_ni(be_ni),
    .live_i(live_q), .act_o(act), .cyc_o(cyc), .lanes_o(lanes)
  );

  bsram_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .addr_i(addr_i),
    .order_i(order_i), .addr_o(cur_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= CYC_IDLE;
      lanes_q <= '0;
      wdata_q <= '0;
      live_q  <= 1'b0;
    end else begin
      cyc_q   <= cyc;
      lanes_q <= lanes;
      wdata_q <= wdata_i;
      if (act == ACT_START)     live_q <= 1'b1;
      else if (act == ACT_NONE) live_q <= 1'b0;
    end
  end

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_q), .lanes_i(lanes_q),
    .addr_i(cur_addr), .wdata_i(wdata_q), .rdata_o(rdata), .rvld_o(rvld)
  );

  assign rd_oe_o = rvld && !oe_ni;
  assign rd_o    = rd_oe_o ? rdata : '0;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel1_ni,
  input logic              sel2_i,
  input logic              sel3_ni,
  input logic              strb_cpu_ni,
  input logic              strb_ctl_ni,
  input logic              wr_all_ni,
  input logic              wr_en_ni,
  input logic [LANES-1:0]  be_ni,
  input logic              oe_ni,
  input logic [DATA_W-1:0] rd_o,
  input logic              rd_oe_o
);
  logic sel_ok, wr_req;
  assign sel_ok = !sel1_ni && sel2_i && !sel3_ni;
  assign wr_req = !wr_all_ni || (!wr_en_ni && !(&be_ni));

  p_oe_hiz_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rd_oe_o);

  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_oe_o |-> rd_o == '0);

  p_cpu_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_ni && sel_ok) |-> ##2 (rd_oe_o || oe_ni));

  p_desel_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_ni && !sel1_ni && (!sel2_i || sel3_ni)) |-> ##2 !rd_oe_o);

  p_write_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_cpu_ni && !strb_ctl_ni && sel_ok && wr_req) |-> ##2 !rd_oe_o);
endmodule

bind burst_sram bsram_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel1_ni(sel1_ni), .sel2_i(sel2_i),
  .sel3_ni(sel3_ni), .strb_cpu_ni(strb_cpu_ni), .strb_ctl_ni(strb_ctl_ni),
  .wr_all_ni(wr_all_ni), .wr_en_ni(wr_en_ni), .be_ni(be_ni), .oe_ni(oe_ni),
  .rd_o(rd_o), .rd_oe_o(rd_oe_o)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [5:0]  addr;
  logic [35:0] din, rd;
  logic        sel1_n, sel2, sel3_n, cpu_n, ctl_n, adv_n, gw_n, we_n, order, oe_n, rd_oe;
  logic [3:0]  be_n;
  logic [35:0] mdl [64];
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  burst_sram u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(din),
    .sel1_ni(sel1_n), .sel2_i(sel2), .sel3_ni(sel3_n),
    .strb_cpu_ni(cpu_n), .strb_ctl_ni(ctl_n), .adv_ni(adv_n),
    .wr_all_ni(gw_n), .wr_en_ni(we_n), .be_ni(be_n), .order_i(order),
    .oe_ni(oe_n), .rd_o(rd), .rd_oe_o(rd_oe)
  );

  task automatic chk(input string tag, input bit ok, input logic [36:0] act, input logic [36:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [35:0] exp);
    chk(tag, rd_oe === 1'b1 && rd === exp, {rd_oe, rd}, {1'b1, exp});
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic idle_in();
    cpu_n = 1; ctl_n = 1; adv_n = 1; gw_n = 1; we_n = 1; be_n = 4'hF;
    sel1_n = 0; sel2 = 1; sel3_n = 0;
  endtask

  task automatic desel_in();
    idle_in(); ctl_n = 0; sel1_n = 1;
  endtask

  task automatic wr_word(input logic [5:0] a, input logic [35:0] d,
                         input logic gw, input logic we, input logic [3:0] be);
    idle_in(); ctl_n = 0; addr = a; din = d; gw_n = gw; we_n = we; be_n = be;
    tick(); desel_in(); tick();
  endtask

  task automatic rd_word(input logic [5:0] a, input string tag);
    idle_in(); cpu_n = 0; addr = a; tick(); desel_in(); tick();
    chk_rd(tag, mdl[a]);
  endtask

  // R1 R5: global write ignores byte enables, controller strobe opens the write
  task automatic t_global();
    for (int i = 0; i < 64; i++) mdl[i] = 36'h0;
    wr_word(6'd5, 36'h9_1234_5678, 1'b0, 1'b1, 4'hF);
    mdl[5] = 36'h9_1234_5678;
    rd_word(6'd5, "R1 global write all lanes");
    wr_word(6'd9, 36'hA_AAAA_AAAA, 1'b0, 1'b0, 4'b0101);
    mdl[9] = 36'hA_AAAA_AAAA;
    rd_word(6'd9, "R5 controller write");
  endtask

  // R2: lanes 0 and 2 enabled (be_n=1010)
  task automatic t_byte();
    wr_word(6'd9, 36'h5_5555_5555, 1'b1, 1'b0, 4'b1010);
    mdl[9] = {mdl[9][35:27], 9'h155, mdl[9][17:9], 9'h155};
    rd_word(6'd9, "R2 byte lanes");
  endtask

  // R3: controller strobe, no write asserted -> read, memory unchanged
  task automatic t_ctl_read();
    idle_in(); ctl_n = 0; addr = 6'd9; din = 36'h0_DEAD_BEEF; we_n = 0; be_n = 4'hF;
    tick(); desel_in(); tick();
    chk_rd("R3 controller read", mdl[9]);
    idle_in(); ctl_n = 0; addr = 6'd9; din = 36'h0_DEAD_BEEF; gw_n = 1; we_n = 1; be_n = 4'h0;
    tick(); desel_in(); tick();
    chk_rd("R3 read with we high", mdl[9]);
    rd_word(6'd9, "R3 memory unchanged");
  endtask

  // R4: processor strobe reads even with writes and controller strobe asserted
  task automatic t_cpu_read();
    idle_in(); cpu_n = 0; ctl_n = 0; addr = 6'd5; din = 36'h0; gw_n = 0; we_n = 0; be_n = 4'h0;
    tick(); desel_in(); tick();
    chk_rd("R4 processor read priority", mdl[5]);
    rd_word(6'd5, "R4 no write performed");
  endtask

  // R6: deselect variants and ignored processor strobe
  task automatic t_desel();
    for (int v = 0; v < 4; v++) begin
      idle_in(); cpu_n = 0; addr = 6'd5; tick();
      idle_in();
      case (v)
        0: begin cpu_n = 0; sel2 = 0; end
        1: begin cpu_n = 0; sel3_n = 1; end
        2: begin ctl_n = 0; sel2 = 0; end
        default: begin ctl_n = 0; sel1_n = 1; end
      endcase
      tick();
      chk_rd("R6 data before drain", mdl[5]);
      idle_in(); tick();
      chk("R6 bus released", rd_oe === 1'b0, {36'h0, rd_oe}, 37'h0);
      tick();
      chk("R6 stays deselected", rd_oe === 1'b0, {36'h0, rd_oe}, 37'h0);
    end
    idle_in(); cpu_n = 0; addr = 6'd9; tick();
    idle_in(); sel1_n = 1; cpu_n = 0; addr = 6'd5; tick();
    tick();
    chk_rd("R6 ignored strobe keeps burst", mdl[9]);
    desel_in(); tick(); tick();
  endtask

  // R7: linear burst write 12..15, then linear read from 14
  task automatic t_linear();
    idle_in(); ctl_n = 0; gw_n = 0; addr = 6'd12; din = 36'h1_0000_0001; tick();
    for (int i = 1; i < 4; i++) begin
      idle_in(); adv_n = 0; gw_n = 0; din = 36'h1_0000_0001 + 36'(i); tick();
    end
    desel_in(); tick(); tick();
    for (int i = 0; i < 4; i++) mdl[12+i] = 36'h1_0000_0001 + 36'(i);
    order = 0;
    idle_in(); cpu_n = 0; addr = 6'd14; tick();
    for (int i = 0; i < 4; i++) begin
      if (i < 3) begin idle_in(); adv_n = 0; end else desel_in();
      tick();
      chk_rd("R7 linear burst", mdl[{4'd3, 2'(2 + i)}]);
    end
    tick();
  endtask

  // R8: interleaved burst from 13 -> 13,12,15,14
  task automatic t_inter();
    order = 1;
    idle_in(); cpu_n = 0; addr = 6'd13; tick();
    for (int i = 0; i < 4; i++) begin
      if (i < 3) begin idle_in(); adv_n = 0; end else desel_in();
      tick();
      chk_rd("R8 interleaved burst", mdl[{4'd3, 2'(2'b01 ^ 2'(i))}]);
    end
    tick();
    order = 0;
  endtask

  // R9 R11: suspend holds address; oe acts without a clock
  task automatic t_suspend();
    idle_in(); cpu_n = 0; addr = 6'd12; tick();
    idle_in(); tick();
    chk_rd("R9 first word", mdl[12]);
    idle_in(); adv_n = 0; tick();
    chk_rd("R9 suspended word", mdl[12]);
    #0.5 oe_n = 1; #0.5;
    chk("R11 oe high releases bus", rd_oe === 1'b0 && rd === 36'h0, {rd_oe, rd}, 37'h0);
    oe_n = 0; #0.5;
    chk_rd("R11 oe low drives again", mdl[12]);
    desel_in(); tick();
    chk_rd("R9 advanced word", mdl[13]);
    tick();
  endtask

  // R10: read right after write, latency
  task automatic t_raw();
    idle_in(); ctl_n = 0; gw_n = 0; addr = 6'd20; din = 36'hC_0FFE_E123; tick();
    mdl[20] = 36'hC_0FFE_E123;
    idle_in(); cpu_n = 0; addr = 6'd20; tick();
    chk("R10 no data after write cycle", rd_oe === 1'b0, {36'h0, rd_oe}, 37'h0);
    desel_in(); tick();
    chk_rd("R10 read after write", mdl[20]);
    idle_in(); cpu_n = 0; addr = 6'd5; tick();
    chk("R10 not yet valid one edge after request", rd_oe === 1'b0, {36'h0, rd_oe}, 37'h0);
    desel_in(); tick();
    chk_rd("R10 valid after second edge", mdl[5]);
    tick();
  endtask

  initial begin
    idle_in(); addr = '0; din = '0; order = 0; oe_n = 0;
    repeat (3) tick();
    chk("R12 reset output", rd_oe === 1'b0, {36'h0, rd_oe}, 37'h0);
    rst_ni = 1'b1;
    desel_in(); tick();
    t_global();
    t_byte();
    t_ctl_read();
    t_cpu_read();
    t_desel();
    t_linear();
    t_inter();
    t_suspend();
    t_raw();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule